// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. It first fetches one entry from a level-1 master table, whose base is held in a programmable table-base register. If that entry maps a 1 MB section, or is a fault entry, the walk ends after that single read. If the entry points to a coarse or fine level-2 table, a second read fetches a level-2 entry. That entry maps a 64 KB, 4 KB or 1 KB page, or is a fault entry.

The response carries the physical address, the domain number, a 2-bit access-permission code, the cacheable and bufferable flags and the mapping size. On a fault it carries a fault flag and the level that faulted. Checking the permissions is left to the consumer. The lookup request, the lookup response and the memory read request are valid/ready handshakes. A transfer happens on a clock edge where both valid and ready are high. A source that raises valid keeps it high and keeps its payload unchanged until that edge. The memory read data comes back as a single-cycle pulse on `mem_rsp_valid`, with no ready signal. Only one walk is in flight at a time, and each walk has at most one memory read outstanding.

Top module: `ptw_walker`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The first read of a walk is at address {table base bits [31:14], VA[31:20], 2'b00}. The table base is the 18-bit value last written through `base_we`/`base_wdata`, and a new value applies to every request accepted after the write.
- R3: A level-1 entry with bits [1:0] = 10 is a section. The response is then PA = {entry[31:20], VA[19:0]}, domain = entry[7:4], permission = entry[9:8], cacheable = entry[3], bufferable = entry[2] and size code 0 (1 MB), and the walk makes exactly one memory read.
- R4: A level-1 entry with bits [1:0] = 00 gives `rsp_fault` = 1 and `rsp_fault_l2` = 0, with PA, domain, permission, cacheable, bufferable and size all 0, after exactly one memory read.
- R5: A level-1 entry with bits [1:0] = 01 points to a coarse table. The second read is then at {entry[31:10], VA[19:12], 2'b00}, and the response domain is entry[7:4] of the level-1 entry.
- R6: A level-1 entry with bits [1:0] = 11 points to a fine table. The second read is then at {entry[31:12], VA[19:10], 2'b00}, and the response domain is entry[7:4] of the level-1 entry.
- R7: A level-2 entry with bits [1:0] = 01 is a large page. The response is then PA = {entry[31:16], VA[15:0]}, size code 1 (64 KB), cacheable = entry[3] and bufferable = entry[2]. The permission is entry[2k+5:2k+4] with k = VA[15:14].
- R8: A level-2 entry with bits [1:0] = 10 is a small page. The response is then PA = {entry[31:12], VA[11:0]}, size code 2 (4 KB), cacheable = entry[3] and bufferable = entry[2]. The permission is entry[2k+5:2k+4] with k = VA[11:10].
- R9: A level-2 entry with bits [1:0] = 11 is a tiny page. The response is then PA = {entry[31:10], VA[9:0]}, permission = entry[5:4], size code 3 (1 KB), cacheable = entry[3] and bufferable = entry[2].
- R10: A level-2 entry with bits [1:0] = 00 gives `rsp_fault` = 1 and `rsp_fault_l2` = 1, with all other response fields 0, after exactly two memory reads.
- R11: `req_ready` is low from the cycle after a request is accepted until the response has been taken, so a request held valid during a walk is accepted only after that handshake. After a memory read handshake, `mem_req_valid` stays low until read data has returned.
- R12: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and all of its fields stay unchanged. While `mem_req_valid` is high and `mem_req_ready` is low, the read stays requested at an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Write strobe for the table-base register |
| base_wdata | input | 18 | Table base bits [31:14] |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker can accept a lookup |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | 32 | Translated physical address |
| rsp_domain | output | 4 | Domain number of the mapping |
| rsp_ap | output | 2 | Selected access-permission code |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_bufferable | output | 1 | Bufferable attribute |
| rsp_size | output | 2 | Mapping size: 0 1 MB, 1 64 KB, 2 4 KB, 3 1 KB |
| rsp_fault | output | 1 | Translation fault |
| rsp_fault_l2 | output | 1 | Fault came from the level-2 entry |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Descriptor word address (byte address, word aligned) |
| mem_rsp_valid | input | 1 | Read data valid, one-cycle pulse |
| mem_rdata | input | 32 | Descriptor read data |

## Verification
The hardest case to reach is a second lookup that arrives while a two-level walk is still busy. In that case the read request is stalled, the read data comes back late, and the consumer is holding the response off. Only that combination tests the single-walk rule and both hold rules together. The bench reaches it with a coarse-table walk during which the memory model withholds `mem_req_ready` for several cycles and delays its data. The consumer keeps `rsp_ready` low for four cycles while the next request's valid stays asserted throughout. That next request must then be accepted only after the first response has been taken.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W    = 32;
  localparam int ALIGN_W   = 14;
  localparam int BASE_W    = ADDR_W - ALIGN_W;
  localparam int L1_IDX_W  = 12;
  localparam int SEC_OFF_W = ADDR_W - L1_IDX_W;
  localparam int DOM_W     = 4;
  localparam int AP_W      = 2;
  localparam int AP_SETS   = 4;
  localparam int AP_ALL_W  = AP_W * AP_SETS;
  localparam int AP2_LSB   = 4;

  typedef enum logic [1:0] {
    L1_FAULT   = 2'b00,
    L1_COARSE  = 2'b01,
    L1_SECTION = 2'b10,
    L1_FINE    = 2'b11
  } l1_kind_e;

  typedef enum logic [1:0] {
    L2_FAULT = 2'b00,
    L2_LARGE = 2'b01,
    L2_SMALL = 2'b10,
    L2_TINY  = 2'b11
  } l2_kind_e;

  typedef enum logic [1:0] {
    SZ_1M  = 2'd0,
    SZ_64K = 2'd1,
    SZ_4K  = 2'd2,
    SZ_1K  = 2'd3
  } map_size_e;

  typedef struct packed {
    logic [ADDR_W-1:0] pa;
    logic [DOM_W-1:0]  domain;
    logic [AP_W-1:0]   ap;
    logic              cacheable;
    logic              bufferable;
    map_size_e         size;
    logic              fault;
    logic              fault_l2;
  } xlat_t;

  function automatic logic [AP_W-1:0] ap_pick(input logic [AP_ALL_W-1:0] f,
                                              input logic [1:0] k);
    return f[{k, 1'b0} +: AP_W];
  endfunction
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BASE_W-1:0] wdata,
  output logic [BASE_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n)  base <= '0;
    else if (we) base <= wdata;
  end
endmodule

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0]    desc,
  input  logic [SEC_OFF_W-1:0] va_lo,
  output l1_kind_e             kind,
  output xlat_t                leaf,
  output logic [ADDR_W-1:0]    l2_addr,
  output logic [DOM_W-1:0]     domain
);
  always_comb begin
    kind    = l1_kind_e'(desc[1:0]);
    domain  = desc[7:4];
    leaf    = '0;
    l2_addr = '0;
    case (kind)
      L1_SECTION: begin
        leaf.pa         = {desc[ADDR_W-1:SEC_OFF_W], va_lo};
        leaf.domain     = desc[7:4];
        leaf.ap         = desc[9:8];
        leaf.cacheable  = desc[3];
        leaf.bufferable = desc[2];
        leaf.size       = SZ_1M;
      end
      L1_COARSE: l2_addr = {desc[ADDR_W-1:10], va_lo[19:12], 2'b00};
      L1_FINE:   l2_addr = {desc[ADDR_W-1:12], va_lo[19:10], 2'b00};
      default:   leaf.fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [15:0]       va_lo,
  input  logic [DOM_W-1:0]  domain_in,
  output xlat_t             leaf
);
  l2_kind_e              kind;
  logic [AP_ALL_W-1:0]   ap_f;

  always_comb begin
    kind = l2_kind_e'(desc[1:0]);
    ap_f = desc[AP2_LSB +: AP_ALL_W];
    leaf = '0;
    case (kind)
      L2_LARGE: begin
        leaf.pa   = {desc[ADDR_W-1:16], va_lo[15:0]};
        leaf.ap   = ap_pick(ap_f, va_lo[15:14]);
        leaf.size = SZ_64K;
      end
      L2_SMALL: begin
        leaf.pa   = {desc[ADDR_W-1:12], va_lo[11:0]};
        leaf.ap   = ap_pick(ap_f, va_lo[11:10]);
        leaf.size = SZ_4K;
      end
      L2_TINY: begin
        leaf.pa   = {desc[ADDR_W-1:10], va_lo[9:0]};
        leaf.ap   = ap_f[AP_W-1:0];
        leaf.size = SZ_1K;
      end
      default: begin
        leaf.fault    = 1'b1;
        leaf.fault_l2 = 1'b1;
      end
    endcase
    if (kind != L2_FAULT) begin
      leaf.domain     = domain_in;
      leaf.cacheable  = desc[3];
      leaf.bufferable = desc[2];
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic [DOM_W-1:0]  rsp_domain,
  output logic [AP_W-1:0]   rsp_ap,
  output logic              rsp_cacheable,
  output logic              rsp_bufferable,
  output logic [1:0]        rsp_size,
  output logic              rsp_fault,
  output logic              rsp_fault_l2,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rdata
);
  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_RESP
  } walk_state_e;

  walk_state_e          state;
  logic [BASE_W-1:0]    base;
  logic [SEC_OFF_W-1:0] va_q;
  logic [ADDR_W-1:0]    mem_addr_q;
  logic [DOM_W-1:0]     dom_q;
  xlat_t                rsp_q;

  l1_kind_e             l1_kind;
  xlat_t                l1_leaf;
  logic [ADDR_W-1:0]    l1_next;
  logic [DOM_W-1:0]     l1_dom;
  xlat_t                l2_leaf;

  ptw_base_reg u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (base_we),
    .wdata (base_wdata),
    .base  (base)
  );

  ptw_l1_dec u_l1 (
    .desc    (mem_rdata),
    .va_lo   (va_q),
    .kind    (l1_kind),
    .leaf    (l1_leaf),
    .l2_addr (l1_next),
    .domain  (l1_dom)
  );

  ptw_l2_dec u_l2 (
    .desc      (mem_rdata),
    .va_lo     (va_q[15:0]),
    .domain_in (dom_q),
    .leaf      (l2_leaf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      va_q       <= '0;
      mem_addr_q <= '0;
      dom_q      <= '0;
      rsp_q      <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q       <= req_va[SEC_OFF_W-1:0];
          mem_addr_q <= {base, req_va[ADDR_W-1:SEC_OFF_W], 2'b00};
          state      <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready) state <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          if (l1_kind == L1_COARSE || l1_kind == L1_FINE) begin
            mem_addr_q <= l1_next;
            dom_q      <= l1_dom;
            state      <= S_L2_REQ;
          end else begin
            rsp_q <= l1_leaf;
            state <= S_RESP;
          end
        end
        S_L2_REQ: if (mem_req_ready) state <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          rsp_q <= l2_leaf;
          state <= S_RESP;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready      = (state == S_IDLE);
  assign rsp_valid      = (state == S_RESP);
  assign mem_req_valid  = (state == S_L1_REQ) || (state == S_L2_REQ);
  assign mem_addr       = mem_addr_q;
  assign rsp_pa         = rsp_q.pa;
  assign rsp_domain     = rsp_q.domain;
  assign rsp_ap         = rsp_q.ap;
  assign rsp_cacheable  = rsp_q.cacheable;
  assign rsp_bufferable = rsp_q.bufferable;
  assign rsp_size       = rsp_q.size;
  assign rsp_fault      = rsp_q.fault;
  assign rsp_fault_l2   = rsp_q.fault_l2;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_q))); // R12
  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr))); // R12
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R11
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && rsp_domain == '0 && rsp_ap == '0)); // R4
  AST_L2_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault_l2) |-> rsp_fault); // R10
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_pa[9:0] == va_q[9:0])); // R9
endmodule

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [17:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_domain;
  logic [1:0]  rsp_ap;
  logic        rsp_cacheable, rsp_bufferable;
  logic [1:0]  rsp_size;
  logic        rsp_fault, rsp_fault_l2;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rdata;

  always #2.5 clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_domain(rsp_domain), .rsp_ap(rsp_ap), .rsp_cacheable(rsp_cacheable),
    .rsp_bufferable(rsp_bufferable), .rsp_size(rsp_size), .rsp_fault(rsp_fault),
    .rsp_fault_l2(rsp_fault_l2), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
  );

  typedef struct packed {
    logic [31:0] va, l1a, d1, l2a, d2, pa;
    logic [3:0]  dom;
    logic [1:0]  ap;
    logic        c, b;
    logic [1:0]  sz;
    logic        flt, flt2;
    logic [1:0]  nrd;
    logic [3:0]  tg;
    logic [3:0]  ta;
  } vec_t;

  localparam int NV = 8;
  // table base 0x0004_0000
  localparam vec_t VECS [NV] = '{
    // R3 section
    '{32'h12345678, 32'h0004048C, 32'hABC0035A, 32'h0, 32'h0, 32'hABC45678,
      4'd5, 2'd3, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 4'd3, 4'd0},
    // R4 level-1 fault
    '{32'h80000000, 32'h00042000, 32'hFFFFFFFC, 32'h0, 32'h0, 32'h0,
      4'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 4'd4, 4'd0},
    // R5 coarse + R8 small
    '{32'h00123ABC, 32'h00040004, 32'h00081491, 32'h0008148C, 32'h55667E46, 32'h55667ABC,
      4'd9, 2'd2, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd2, 4'd8, 4'd5},
    // R6 fine + R9 tiny
    '{32'h7FF04D21, 32'h00041FFC, 32'h000930F3, 32'h0009304C, 32'h1234541F, 32'h12345521,
      4'd15, 2'd1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 2'd2, 4'd9, 4'd6},
    // R5 coarse + R7 large
    '{32'h00368123, 32'h0004000C, 32'h00082021, 32'h000821A0, 32'hBEEF01B9, 32'hBEEF8123,
      4'd2, 2'd1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 2'd2, 4'd7, 4'd5},
    // R10 level-2 fault
    '{32'h00500000, 32'h00040014, 32'h00083071, 32'h00083000, 32'hFFFFFFFC, 32'h0,
      4'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd2, 4'd10, 4'd5},
    // R6 fine + R7 large, top permission subfield
    '{32'h0067F9A0, 32'h00040018, 32'h00094013, 32'h000947F8, 32'h13570805, 32'h1357F9A0,
      4'd1, 2'd2, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd2, 4'd7, 4'd6},
    // R3 section at the top index
    '{32'hFFFFFFFF, 32'h00043FFC, 32'h00100106, 32'h0, 32'h0, 32'h001FFFFF,
      4'd0, 2'd1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd1, 4'd3, 4'd0}
  };

  int checks = 0;
  int fails  = 0;

  function automatic string tname(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory model state
  logic [31:0] cur_l1a, cur_d1, cur_l2a, cur_d2;
  logic [3:0]  cur_ta;
  int          rd_cnt = 0;
  int          mem_stall = 0;
  int          mem_lat = 0;

  initial begin
    logic [31:0] a0, rd_data;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rdata     = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        a0 = mem_addr;
        for (int i = 0; i < mem_stall; i++) begin
          @(negedge clk);
          chk("R12", "read held while stalled", {31'b0, mem_req_valid}, 32'd1);
          chk("R12", "address held while stalled", mem_addr, a0);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (rd_cnt == 0) chk("R2", "level-1 read address", a0, cur_l1a);
        else             chk(tname(cur_ta), "level-2 read address", a0, cur_l2a);
        rd_data = (rd_cnt == 0) ? cur_d1 : cur_d2;
        rd_cnt++;
        chk("R11", "no read while data pending", {31'b0, mem_req_valid}, 32'd0);
        for (int i = 0; i < mem_lat; i++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rdata     = rd_data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rdata     = 32'hDEADBEEF;
      end
    end
  end

  task automatic run_walk(input vec_t v, input int hold, input int stall,
                          input int lat, input bit keep, input logic [31:0] nva);
    string t;
    logic [31:0] snap_pa;
    logic [15:0] snap_attr;
    t = tname(v.tg);
    cur_l1a = v.l1a; cur_d1 = v.d1; cur_l2a = v.l2a; cur_d2 = v.d2; cur_ta = v.ta;
    rd_cnt = 0; mem_stall = stall; mem_lat = lat;
    req_valid = 1'b1;
    req_va    = v.va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (keep) req_va = nva;
    else      req_valid = 1'b0;
    while (!rsp_valid) begin
      chk("R11", "busy walker refuses requests", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
    end
    chk(t, "pa", rsp_pa, v.pa);
    chk(t, "domain", {28'b0, rsp_domain}, {28'b0, v.dom});
    chk(t, "ap", {30'b0, rsp_ap}, {30'b0, v.ap});
    chk(t, "cacheable/bufferable", {30'b0, rsp_cacheable, rsp_bufferable}, {30'b0, v.c, v.b});
    chk(t, "size", {30'b0, rsp_size}, {30'b0, v.sz});
    chk(t, "fault/level", {30'b0, rsp_fault, rsp_fault_l2}, {30'b0, v.flt, v.flt2});
    snap_pa   = rsp_pa;
    snap_attr = {rsp_domain, rsp_ap, rsp_cacheable, rsp_bufferable, rsp_size,
                 rsp_fault, rsp_fault_l2, 4'b0};
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R12", "response held valid", {31'b0, rsp_valid}, 32'd1);
      chk("R12", "response pa stable", rsp_pa, snap_pa);
      chk("R12", "response attributes stable",
          {16'b0, rsp_domain, rsp_ap, rsp_cacheable, rsp_bufferable, rsp_size,
           rsp_fault, rsp_fault_l2, 4'b0}, {16'b0, snap_attr});
      chk("R11", "no accept while response pending", {31'b0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R11", "response retired", {31'b0, rsp_valid}, 32'd0);
    chk(t, "memory reads per walk", rd_cnt, {30'b0, v.nrd});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "req_ready in reset", {31'b0, req_ready}, 32'd1);
    chk("R1", "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    chk("R1", "mem_req_valid in reset", {31'b0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'b100);

    base_we = 1'b1; base_wdata = 18'h00010;
    @(negedge clk);
    base_we = 1'b0;

    for (int i = 0; i < NV; i++) run_walk(VECS[i], i % 3, i % 2, (i + 1) % 3, 1'b0, 32'h0);

    // stalled coarse walk, held response, next request waiting throughout
    run_walk(VECS[2], 4, 3, 2, 1'b1, VECS[0].va);
    run_walk(VECS[0], 0, 0, 0, 1'b0, 32'h0);

    // R2 new table base applies to the next request
    base_we = 1'b1; base_wdata = 18'h00200;
    @(negedge clk);
    base_we = 1'b0;
    run_walk('{32'h00100000, 32'h00800004, 32'hCDE00002, 32'h0, 32'h0, 32'hCDE00000,
               4'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 4'd2, 4'd0},
             1, 2, 0, 1'b0, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule